// File: doc/BRIEF.md
# Pulsed Cartesian Field Feedback Controller

This block regulates the RF field of a pair of cavities during a pulse, working entirely in in-phase/quadrature (I/Q) coordinates. Each sample, the two cavities' I/Q readings are added into one vector sum. That sum is subtracted from a setpoint that is read from a table. A new table entry is used on every sample of the pulse, so the setpoint can follow a shaped rise, for example an exponential climb to a flat top of I = 6000, Q = 0. The I and Q lanes each get the same proportional and integral gains. Each lane then adds a feed-forward value from a second table. While the beam gate is high, each lane also adds a fixed beam-loading compensation term. The resulting drive words go out to two 14-bit DACs.

A pulse gate frames the operation. While the gate is low, the table pointer stays at zero, the integrators are held cleared and both DAC words are zero. Every sample with the gate high moves the pointer forward by one entry. The tables, the two gains and the two beam terms are loaded through a single-cycle write port. This port can be used between pulses or during a pulse.

Top module: `iq_fb_ctrl`

## Requirements
- R1: The measured vector is formed per component as the sum of the two cavities' readings, saturated to the signed 14-bit range [-8192, 8191].
- R2: The loop error per component is setpoint[idx] minus the vector sum, saturated to the signed 14-bit range.
- R3: Each lane has a signed 14-bit integrator. On every gated sample it takes the value sat14(integrator + error), so it never wraps.
- R4: On each clock edge with the gate high, the DAC word of a lane becomes sat14(((Kp*error + Ki*new_integrator) >>> 8) + feedforward[idx] + beam term). Here >>> is an arithmetic shift, and the result appears after that edge.
- R5: At any edge where the pulse gate is low, both DAC words become zero, both integrators clear and the table pointer returns to 0. The first gated sample therefore uses entry 0 and a zero integrator.
- R6: The table pointer advances by one at each gated edge. It stops at the last entry (63 for 6 address bits) and holds there for the rest of a longer pulse.
- R7: The beam term of a lane enters the sum only on samples where beam_gate is high. Otherwise it contributes zero.
- R8: Write address layout: bits [8:6] select a region and bits [5:0] an offset. The regions are 0 = I setpoint, 1 = Q setpoint, 2 = I feed-forward, 3 = Q feed-forward, and 4 = control. In the control region, offset 0 is Kp, 1 is Ki, 2 is the I beam term and 3 is the Q beam term. Table and beam entries take wr_data[13:0] as signed. Gains take all 16 bits as signed. Regions 5 to 7 and control offsets above 3 change nothing.
- R9: One Kp and one Ki serve both lanes. A write is used by samples at edges after the write edge, and writes are accepted while a pulse runs.
- R10: Synchronous reset zeroes the DAC words, integrators, pointer, gains and beam terms. Table contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_gate | input | 1 | High for the duration of the RF pulse |
| beam_gate | input | 1 | High while beam passes; enables the compensation term |
| cav1_i | input | 14 | Cavity 1 in-phase reading, signed |
| cav1_q | input | 14 | Cavity 1 quadrature reading, signed |
| cav2_i | input | 14 | Cavity 2 in-phase reading, signed |
| cav2_q | input | 14 | Cavity 2 quadrature reading, signed |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 9 | Region (bits 8:6) and offset (bits 5:0) |
| wr_data | input | 16 | Write data |
| dac_i | output | 14 | In-phase drive word, signed |
| dac_q | output | 14 | Quadrature drive word, signed |

## Verification
The assertions check the following on every cycle:
- the gate-low behaviour: zero outputs, a cleared integrator and a pointer at zero;
- the one-step advance of the pointer and its hold at the last entry;
- that the integrator never moves against the sign of the error.

The exact drive arithmetic can only be shown by the bench scenarios, which compare each DAC word against a model computed in the bench. This covers saturation at the sum, error, integrator and output stages, and beam-gate timing. It also covers writes that land mid-pulse, ignored addresses, and setpoint steps of 6000, 5000 and 4000 under unchanged gains.

// File: rtl/iq_fb_pkg.sv
package iq_fb_pkg;

    localparam int DATA_W  = 14;
    localparam int TBL_AW  = 6;
    localparam int GAIN_W  = 16;
    localparam int GAIN_SH = 8;
    localparam int SEL_W   = 3;
    localparam int LANES   = 2;

    typedef enum logic [SEL_W-1:0] {
        RG_SET_I = 3'd0,
        RG_SET_Q = 3'd1,
        RG_FF_I  = 3'd2,
        RG_FF_Q  = 3'd3,
        RG_CTRL  = 3'd4
    } wr_region_e;

    typedef enum logic [1:0] {
        CT_KP     = 2'd0,
        CT_KI     = 2'd1,
        CT_BEAM_I = 2'd2,
        CT_BEAM_Q = 2'd3
    } ctrl_reg_e;

    function automatic wr_region_e set_region(input int lane);
        return (lane == 0) ? RG_SET_I : RG_SET_Q;
    endfunction

    function automatic wr_region_e ff_region(input int lane);
        return (lane == 0) ? RG_FF_I : RG_FF_Q;
    endfunction

    function automatic ctrl_reg_e beam_reg(input int lane);
        return (lane == 0) ? CT_BEAM_I : CT_BEAM_Q;
    endfunction

endpackage

// File: rtl/iq_fb_regs.sv
module iq_fb_regs
    import iq_fb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = TBL_AW,
    parameter int GW = GAIN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW+SEL_W-1:0]     wr_addr,
    input  logic [GW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_idx,
    output logic signed [DW-1:0]    set_val  [LANES],
    output logic signed [DW-1:0]    ff_val   [LANES],
    output logic signed [DW-1:0]    beam_val [LANES],
    output logic signed [GW-1:0]    kp,
    output logic signed [GW-1:0]    ki
);

    localparam int DEPTH = 1 << AW;

    wr_region_e          rg;
    logic [AW-1:0]       off;
    logic                ctrl_hit;
    ctrl_reg_e           creg;
    logic signed [DW-1:0] wdat_tbl;

    assign rg       = wr_region_e'(wr_addr[AW+SEL_W-1:AW]);
    assign off      = wr_addr[AW-1:0];
    assign creg     = ctrl_reg_e'(off[1:0]);
    assign ctrl_hit = wr_en && (rg == RG_CTRL) && (off[AW-1:2] == '0);
    assign wdat_tbl = wr_data[DW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            kp <= '0;
            ki <= '0;
        end else if (ctrl_hit) begin
            if (creg == CT_KP) kp <= wr_data;
            if (creg == CT_KI) ki <= wr_data;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [DW-1:0] set_mem [DEPTH];
        logic signed [DW-1:0] ff_mem  [DEPTH];
        logic signed [DW-1:0] beam_r;

        always_ff @(posedge clk) begin
            if (wr_en && rg == set_region(l)) set_mem[off] <= wdat_tbl;
            if (wr_en && rg == ff_region(l))  ff_mem[off]  <= wdat_tbl;
        end

        always_ff @(posedge clk) begin
            if (rst)                                  beam_r <= '0;
            else if (ctrl_hit && creg == beam_reg(l)) beam_r <= wdat_tbl;
        end

        assign set_val[l]  = set_mem[rd_idx];
        assign ff_val[l]   = ff_mem[rd_idx];
        assign beam_val[l] = beam_r;
    end

endmodule

// File: rtl/iq_vsum.sv
module iq_vsum
    import iq_fb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic signed [DW-1:0] cav_a [LANES],
    input  logic signed [DW-1:0] cav_b [LANES],
    output logic signed [DW-1:0] vsum  [LANES]
);

    localparam logic signed [DW-1:0] MAXO = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINO = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW:0]   HI   = (DW+1)'(MAXO);
    localparam logic signed [DW:0]   LO   = (DW+1)'(MINO);

    for (genvar l = 0; l < LANES; l++) begin : g_add
        logic signed [DW:0] s;
        assign s = (DW+1)'(cav_a[l]) + (DW+1)'(cav_b[l]);
        always_comb begin
            if (s > HI)      vsum[l] = MAXO;
            else if (s < LO) vsum[l] = MINO;
            else             vsum[l] = s[DW-1:0];
        end
    end

endmodule

// File: rtl/iq_seq.sv
module iq_seq
    import iq_fb_pkg::*;
#(
    parameter int AW = TBL_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gate,
    output logic [AW-1:0] idx
);

    localparam logic [AW-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst || !gate)   idx <= '0;
        else if (idx != LAST) idx <= idx + 1'b1;
    end

endmodule

// File: rtl/iq_pi_lane.sv
module iq_pi_lane
    import iq_fb_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int GW  = GAIN_W,
    parameter int GSH = GAIN_SH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gate,
    input  logic                 beam,
    input  logic signed [DW-1:0] meas,
    input  logic signed [DW-1:0] setp,
    input  logic signed [DW-1:0] ffv,
    input  logic signed [DW-1:0] beamv,
    input  logic signed [GW-1:0] kp,
    input  logic signed [GW-1:0] ki,
    output logic signed [DW-1:0] drive,
    output logic signed [DW-1:0] integ,
    output logic signed [DW-1:0] err
);

    localparam int PW    = GW + DW;
    localparam int ACC_W = PW + 2;
    localparam logic signed [DW-1:0]    MAXO = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0]    MINO = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HI   = ACC_W'(MAXO);
    localparam logic signed [ACC_W-1:0] LO   = ACC_W'(MINO);

    function automatic logic signed [DW-1:0] sat(input logic signed [ACC_W-1:0] x);
        if (x > HI) return MAXO;
        if (x < LO) return MINO;
        return x[DW-1:0];
    endfunction

    logic signed [ACC_W-1:0] diff, isum, acc, shifted, beam_add, tot;
    logic signed [DW-1:0]    integ_nxt;
    logic signed [PW-1:0]    prod_p, prod_i;

    always_comb begin
        diff      = ACC_W'(setp) - ACC_W'(meas);
        err       = sat(diff);
        isum      = ACC_W'(integ) + ACC_W'(err);
        integ_nxt = sat(isum);
        prod_p    = PW'(kp) * PW'(err);
        prod_i    = PW'(ki) * PW'(integ_nxt);
        acc       = ACC_W'(prod_p) + ACC_W'(prod_i);
        shifted   = acc >>> GSH;
        beam_add  = beam ? ACC_W'(beamv) : '0;
        tot       = shifted + ACC_W'(ffv) + beam_add;
    end

    always_ff @(posedge clk) begin
        if (rst || !gate) begin
            integ <= '0;
            drive <= '0;
        end else begin
            integ <= integ_nxt;
            drive <= sat(tot);
        end
    end

endmodule

// File: rtl/iq_fb_ctrl.sv
module iq_fb_ctrl
    import iq_fb_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = TBL_AW,
    parameter int GW  = GAIN_W,
    parameter int GSH = GAIN_SH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pulse_gate,
    input  logic                    beam_gate,
    input  logic signed [DW-1:0]    cav1_i,
    input  logic signed [DW-1:0]    cav1_q,
    input  logic signed [DW-1:0]    cav2_i,
    input  logic signed [DW-1:0]    cav2_q,
    input  logic                    wr_en,
    input  logic [AW+SEL_W-1:0]     wr_addr,
    input  logic [GW-1:0]           wr_data,
    output logic signed [DW-1:0]    dac_i,
    output logic signed [DW-1:0]    dac_q
);

    logic signed [DW-1:0] cav_a [LANES];
    logic signed [DW-1:0] cav_b [LANES];
    logic signed [DW-1:0] vsum  [LANES];
    logic signed [DW-1:0] setv  [LANES];
    logic signed [DW-1:0] ffv   [LANES];
    logic signed [DW-1:0] beamv [LANES];
    logic signed [DW-1:0] drive [LANES];
    logic signed [DW-1:0] integ [LANES];
    logic signed [DW-1:0] err   [LANES];
    logic signed [GW-1:0] kp, ki;
    logic [AW-1:0]        tbl_idx;
    logic signed [DW-1:0] integ_i_w, err_i_w;

    assign cav_a[0] = cav1_i;
    assign cav_a[1] = cav1_q;
    assign cav_b[0] = cav2_i;
    assign cav_b[1] = cav2_q;

    iq_fb_regs #(.DW(DW), .AW(AW), .GW(GW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(tbl_idx), .set_val(setv), .ff_val(ffv), .beam_val(beamv),
        .kp(kp), .ki(ki)
    );

    iq_vsum #(.DW(DW)) u_vsum (.cav_a(cav_a), .cav_b(cav_b), .vsum(vsum));

    iq_seq #(.AW(AW)) u_seq (.clk(clk), .rst(rst), .gate(pulse_gate), .idx(tbl_idx));

    for (genvar l = 0; l < LANES; l++) begin : g_pi
        iq_pi_lane #(.DW(DW), .GW(GW), .GSH(GSH)) u_lane (
            .clk(clk), .rst(rst), .gate(pulse_gate), .beam(beam_gate),
            .meas(vsum[l]), .setp(setv[l]), .ffv(ffv[l]), .beamv(beamv[l]),
            .kp(kp), .ki(ki), .drive(drive[l]), .integ(integ[l]), .err(err[l])
        );
    end

    assign dac_i     = drive[0];
    assign dac_q     = drive[1];
    assign integ_i_w = integ[0];
    assign err_i_w   = err[0];

endmodule

// File: rtl/iq_fb_ctrl_chk.sv
module iq_fb_ctrl_chk #(
    parameter int DW = 14,
    parameter int AW = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pulse_gate,
    input logic signed [DW-1:0] dac_i,
    input logic signed [DW-1:0] dac_q,
    input logic [AW-1:0]        idx,
    input logic signed [DW-1:0] integ_i,
    input logic signed [DW-1:0] err_i
);

    localparam logic [AW-1:0] LAST = '1;

    p_gate_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !pulse_gate |=> (dac_i == '0 && dac_q == '0));

    p_gate_low_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !pulse_gate |=> (idx == '0 && integ_i == '0));

    p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
        (pulse_gate && idx != LAST) |=> (idx == $past(idx) + 1'b1));

    p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (pulse_gate && idx == LAST) |=> (idx == LAST));

    p_integ_up_r3: assert property (@(posedge clk) disable iff (rst)
        (pulse_gate && err_i > 0) |=> (integ_i >= $past(integ_i)));

    p_integ_down_r3: assert property (@(posedge clk) disable iff (rst)
        (pulse_gate && err_i < 0) |=> (integ_i <= $past(integ_i)));

endmodule

bind iq_fb_ctrl iq_fb_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .pulse_gate(pulse_gate), .dac_i(dac_i), .dac_q(dac_q),
    .idx(tbl_idx), .integ_i(integ_i_w), .err_i(err_i_w)
);

// File: tb/iq_fb_ctrl_bench.sv
module iq_fb_ctrl_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_gate = 1'b0, beam_gate = 1'b0;
    logic signed [13:0] cav1_i = '0, cav1_q = '0, cav2_i = '0, cav2_q = '0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic signed [13:0] dac_i, dac_q;

    always #10 clk = ~clk;

    iq_fb_ctrl u_iq_fb_ctrl (
        .clk(clk), .rst(rst), .pulse_gate(pulse_gate), .beam_gate(beam_gate),
        .cav1_i(cav1_i), .cav1_q(cav1_q), .cav2_i(cav2_i), .cav2_q(cav2_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dac_i(dac_i), .dac_q(dac_q)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    string cur_req = "R10";

    int m_set[2][64], m_ff[2][64], m_bc[2];
    int m_kp = 0, m_ki = 0, m_integ[2], m_idx = 0, m_exp[2];

    function automatic int sat14(input int x);
        if (x > 8191) return 8191;
        if (x < -8192) return -8192;
        return x;
    endfunction

    function automatic int sx(input int v, input int w);
        int m = v & ((1 << w) - 1);
        if (m >= (1 << (w - 1))) m -= (1 << w);
        return m;
    endfunction

    function automatic int rnd14();
        return int'($urandom_range(16383)) - 8192;
    endfunction

    task automatic compare();
        n_vec += 2;
        if (int'(dac_i) != m_exp[0]) begin
            n_bad++;
            $display("FAIL %s lane I: got %0d expected %0d", cur_req, dac_i, m_exp[0]);
        end
        if (int'(dac_q) != m_exp[1]) begin
            n_bad++;
            $display("FAIL %s lane Q: got %0d expected %0d", cur_req, dac_q, m_exp[1]);
        end
    endtask

    // one sample: drive at negedge, model the edge, check at next negedge
    task automatic cyc(input bit g, input bit b, input int c1i, input int c1q,
                       input int c2i, input int c2q,
                       input bit we = 0, input int wa = 0, input int wd = 0);
        int c1[2], c2[2];
        pulse_gate = g; beam_gate = b;
        cav1_i = 14'(c1i); cav1_q = 14'(c1q); cav2_i = 14'(c2i); cav2_q = 14'(c2q);
        wr_en = we; wr_addr = 9'(wa); wr_data = 16'(wd);
        c1[0] = c1i; c1[1] = c1q; c2[0] = c2i; c2[1] = c2q;
        if (!g) begin
            m_idx = 0;
            m_integ = '{0, 0};
            m_exp = '{0, 0};
        end else begin
            for (int l = 0; l < 2; l++) begin
                int vs, e, in, acc;
                vs = sat14(c1[l] + c2[l]);
                e  = sat14(m_set[l][m_idx] - vs);
                in = sat14(m_integ[l] + e);
                acc = (m_kp * e + m_ki * in) >>> 8;
                m_exp[l] = sat14(acc + m_ff[l][m_idx] + (b ? m_bc[l] : 0));
                m_integ[l] = in;
            end
            if (m_idx != 63) m_idx++;
        end
        if (we) begin
            int rg = (wa >> 6) & 7, off = wa & 63;
            case (rg)
                0: m_set[0][off] = sx(wd, 14);
                1: m_set[1][off] = sx(wd, 14);
                2: m_ff[0][off]  = sx(wd, 14);
                3: m_ff[1][off]  = sx(wd, 14);
                4: case (off)
                       0: m_kp = sx(wd, 16);
                       1: m_ki = sx(wd, 16);
                       2: m_bc[0] = sx(wd, 14);
                       3: m_bc[1] = sx(wd, 14);
                       default: ;
                   endcase
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        compare();
    endtask

    task automatic wr(input int rg, input int off, input int d);
        cyc(0, 0, 0, 0, 0, 0, 1, (rg << 6) | off, d);
    endtask

    task automatic do_reset();
        rst = 1'b1; pulse_gate = 1'b0; wr_en = 1'b0;
        m_kp = 0; m_ki = 0; m_bc = '{0, 0}; m_integ = '{0, 0}; m_idx = 0; m_exp = '{0, 0};
        repeat (2) @(posedge clk);
        @(negedge clk);
        cur_req = "R10";
        compare();
        rst = 1'b0;
    endtask

    task automatic load_flat(input int top);
        for (int k = 0; k < 64; k++) begin
            int v = (k < 40) ? $rtoi(real'(top) * (1.0 - $exp(-real'(k) / 8.0))) : top;
            wr(0, k, v);
            wr(1, k, 0);
        end
    endtask

    task automatic pulse_noise(input int len, input int centre, input int spread, input bit beam_rand);
        for (int n = 0; n < len; n++) begin
            int d = int'($urandom_range(2 * spread)) - spread;
            cyc(1, beam_rand ? bit'($urandom_range(1)) : 1'b0,
                centre / 2 + d, d / 3, centre / 2 - d / 2, -d / 4);
        end
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        cur_req = "R8";
        load_flat(6000);
        for (int k = 0; k < 64; k++) begin
            wr(2, k, 1500 + k * 10);
            wr(3, k, -k * 4);
        end
        wr(4, 0, 96); wr(4, 1, 6); wr(4, 2, -300); wr(4, 3, 150);
        wr(5, 0, 4000);   // unused region: ignored
        wr(4, 9, 1234);   // unused control offset: ignored

        cur_req = "R4";
        pulse_noise(80, 6000, 400, 0);
        cur_req = "R7";
        pulse_noise(50, 5800, 200, 1);
        cur_req = "R5";
        for (int n = 0; n < 4; n++) cyc(0, 1, 3000, 100, 3000, 100);
        cur_req = "R6";
        pulse_noise(130, 6100, 100, 0);

        cur_req = "R9";
        load_flat(5000);
        pulse_noise(70, 5000, 300, 1);
        load_flat(4000);
        pulse_noise(70, 4000, 300, 1);

        cur_req = "R9";
        for (int n = 0; n < 30; n++) begin
            if (n == 10) begin
                cyc(1, 0, 2000, 0, 2000, 0, 1, (4 << 6) | 0, 200);
                continue;
            end
            if (n == 15) begin
                cyc(1, 1, 2000, 0, 2000, 0, 1, (3 << 6) | 20, -777);
                continue;
            end
            cyc(1, n[0], 2000, 10, 2000, -10);
        end
        cyc(0, 0, 0, 0, 0, 0);

        cur_req = "R1";
        for (int n = 0; n < 5; n++) cyc(1, 0, 8191, -8192, 8191, -8192);
        cyc(0, 0, 0, 0, 0, 0);
        cur_req = "R2";
        wr(4, 0, 2000); wr(4, 1, 50);
        for (int n = 0; n < 6; n++) cyc(1, 0, -8192, 8191, -8192, 8191);
        cur_req = "R3";
        for (int n = 0; n < 10; n++) cyc(1, 0, -8000, 8000, -8000, 8000);
        for (int n = 0; n < 10; n++) cyc(1, 1, 8000, -8000, 8000, -8000);
        cyc(0, 0, 0, 0, 0, 0);

        cur_req = "R4";
        for (int p = 0; p < 20; p++) begin
            wr(4, 0, int'($urandom_range(65535)));
            wr(4, 1, int'($urandom_range(400)) - 200);
            wr(4, 2, rnd14());
            wr(4, 3, rnd14());
            for (int n = 0; n < int'($urandom_range(110, 10)); n++)
                cyc(1, bit'($urandom_range(1)), rnd14(), rnd14(), rnd14(), rnd14());
            cyc(0, 0, 0, 0, 0, 0);
        end

        cur_req = "R10";
        wr(4, 0, 500); wr(4, 2, 333);
        do_reset();
        for (int n = 0; n < 4; n++) cyc(1, 1, 1000, 1000, 1000, 1000);
        cyc(0, 0, 0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule